// File: doc/BRIEF.md
# AMI Composite Clock Decoder

This block takes a composite timing reference carried as alternate-mark-inversion pulses. The line interface has already sliced the signal into two digital rails, one for positive pulses and one for negative pulses, and both rails are sampled in the system clock domain. The block turns every mark into a one-cycle bit enable for the 64 kHz clock. It locates the 8 kHz boundaries from the marks that deliberately repeat the polarity of the mark before them, and it reports the boundary with a frame pulse once framing has been acquired.

The block also watches the quality of the reference. Marks that appear on both rails at once, boundary violations at the wrong spacing, and missing boundary violations all count as departures. Departures are counted over a programmable window of frames. A disqualify output rises when the count goes above a programmable threshold, and it also rises when the line has been silent for too long. Downstream reference selection logic uses disqualify to switch away from a poor source.

Top module: `ami_cc_decoder`

## Requirements
- R1: A mark is a rising edge on exactly one rail, with the other rail low in the same sample. Each mark gives `bit_en` high for one cycle. The pulse appears 2 clock cycles after the first clock edge that samples the rail high. `rail_p` means positive polarity and `rail_n` means negative polarity.
- R2: A sample with a rising rail while both rails are high is invalid. It gives no `bit_en`, it does not alter the polarity or spacing state, and it counts as one departure.
- R3: A violation is a mark whose polarity equals the polarity of the previous valid mark. Once a first reference violation has been seen since reset, spacing is checked. Spacing is correct when exactly 7 valid marks lie between two violations. Each of the following counts as one spacing error and one departure: a violation that arrives earlier, or an 8th mark that is not a violation. In the second case the 8th mark becomes the new spacing origin.
- R4: `framed` rises on the second consecutive correctly spaced violation that follows the reference violation.
- R5: `frame_pulse` is high together with `bit_en` on a violation mark while framing holds. This includes the mark that acquires framing. It is never high on any other mark.
- R6: Three consecutive spacing errors clear `framed`. A correctly spaced violation resets the error run.
- R7: A frame ends on every violation mark and on every 8th mark without one. Departures are counted per window of `win_frames` frames. `disqualify` rises 3 cycles after the first clock edge that samples the offending mark, as soon as the count exceeds `dep_thresh`. It stays high until a window closes with a count at or below `dep_thresh`. Before the first reference violation, a missing violation is not a departure.
- R8: When no rising rail edge is seen for `idle_limit` cycles, `disqualify` goes high. It goes low again with the next mark, unless R7 holds it high.
- R9: After reset, `bit_en`, `frame_pulse`, `framed` and `disqualify` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the rails |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rail_p | input | 1 | Sampled positive pulse rail |
| rail_n | input | 1 | Sampled negative pulse rail |
| win_frames | input | WIN_W | Length of the departure window in frames |
| dep_thresh | input | THR_W | Highest departure count per window that still qualifies |
| idle_limit | input | IDLE_W | Silent cycles before loss of activity is declared |
| bit_en | output | 1 | One-cycle enable per valid mark |
| frame_pulse | output | 1 | One-cycle boundary marker on a violation mark while framed |
| framed | output | 1 | Framing acquired |
| disqualify | output | 1 | Reference quality failure |

## Verification
`bit_en`, `frame_pulse` and `framed` come from the second register stage, so the bench drives a rail at a falling edge and samples them at the falling edge that follows the second rising edge. `disqualify` takes one more register, so the bench samples it one falling edge later than `bit_en`. The idle timeout is measured against a number of cycles. The bench checks it with margins of about ten cycles on both sides of the limit, which absorbs the reset synchroniser and the pipeline delay.

// File: rtl/ami_cc_pkg.sv
package ami_cc_pkg;

  // One sampled mark after edge detection
  typedef struct packed {
    logic valid;  // mark on exactly one rail
    logic bad;    // rising edge while both rails high
    logic pol;    // 1: positive rail, 0: negative rail
  } mark_t;

endpackage

// File: rtl/ami_mark_det.sv
module ami_mark_det
  import ami_cc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rail_p,
  input  logic  rail_n,
  output mark_t mk_q
);

  logic  prev_p, prev_n;
  logic  rise_p, rise_n, both_hi;
  mark_t mk_d;

  always_comb begin
    rise_p   = rail_p & ~prev_p;
    rise_n   = rail_n & ~prev_n;
    both_hi  = rail_p & rail_n;
    mk_d.valid = (rise_p | rise_n) & ~both_hi;
    mk_d.bad   = (rise_p | rise_n) & both_hi;
    mk_d.pol   = rise_p;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_p <= 1'b0;
      prev_n <= 1'b0;
      mk_q   <= '0;
    end else begin
      prev_p <= rail_p;
      prev_n <= rail_n;
      mk_q   <= mk_d;
    end
  end

endmodule

// File: rtl/ami_framer.sv
module ami_framer
  import ami_cc_pkg::*;
#(
  parameter int FRAME_MARKS = 8,
  parameter int ACQ_VIOL    = 2,
  parameter int LOSS_ERR    = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  mark_t mk,
  output logic  bit_en,
  output logic  frame_pulse,
  output logic  framed,
  output logic  dep_pulse,
  output logic  frame_tick
);

  localparam int SP_W    = $clog2(FRAME_MARKS);
  localparam int RUN_MAX = (ACQ_VIOL > LOSS_ERR) ? ACQ_VIOL : LOSS_ERR;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  logic             last_pol, last_pol_d;
  logic             have_pol, have_pol_d;
  logic             ref_seen, ref_seen_d;
  logic [SP_W-1:0]  sp_cnt, sp_cnt_d;
  logic [RUN_W-1:0] good_run, good_run_d;
  logic [RUN_W-1:0] err_run, err_run_d;
  logic             framed_d;
  logic             viol, at_edge, good, sp_err;

  always_comb begin
    viol    = mk.valid & have_pol & (mk.pol == last_pol);
    at_edge = (sp_cnt == SP_W'(FRAME_MARKS - 1));
    good    = viol & at_edge & ref_seen;
    sp_err  = ref_seen & mk.valid & (viol ? ~at_edge : at_edge);

    last_pol_d = last_pol;
    have_pol_d = have_pol;
    ref_seen_d = ref_seen;
    sp_cnt_d   = sp_cnt;
    if (mk.valid) begin
      last_pol_d = mk.pol;
      have_pol_d = 1'b1;
      sp_cnt_d   = (viol | at_edge) ? '0 : sp_cnt + 1'b1;
      if (viol) ref_seen_d = 1'b1;
    end

    good_run_d = good_run;
    err_run_d  = err_run;
    if (good) begin
      err_run_d  = '0;
      if (good_run != RUN_W'(ACQ_VIOL)) good_run_d = good_run + 1'b1;
    end else if (sp_err) begin
      good_run_d = '0;
      if (err_run != RUN_W'(LOSS_ERR)) err_run_d = err_run + 1'b1;
    end

    framed_d = framed;
    if (good && good_run_d == RUN_W'(ACQ_VIOL))
      framed_d = 1'b1;
    else if (sp_err && err_run_d == RUN_W'(LOSS_ERR))
      framed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pol    <= 1'b0;
      have_pol    <= 1'b0;
      ref_seen    <= 1'b0;
      sp_cnt      <= '0;
      good_run    <= '0;
      err_run     <= '0;
      framed      <= 1'b0;
      bit_en      <= 1'b0;
      frame_pulse <= 1'b0;
      dep_pulse   <= 1'b0;
      frame_tick  <= 1'b0;
    end else begin
      last_pol    <= last_pol_d;
      have_pol    <= have_pol_d;
      ref_seen    <= ref_seen_d;
      sp_cnt      <= sp_cnt_d;
      good_run    <= good_run_d;
      err_run     <= err_run_d;
      framed      <= framed_d;
      bit_en      <= mk.valid;
      frame_pulse <= viol & framed_d;
      dep_pulse   <= mk.bad | sp_err;
      frame_tick  <= mk.valid & (viol | at_edge);
    end
  end

endmodule

// File: rtl/ami_qual_mon.sv
module ami_qual_mon #(
  parameter int WIN_W  = 8,
  parameter int THR_W  = 8,
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dep_pulse,
  input  logic              frame_tick,
  input  logic              activity,
  input  logic [WIN_W-1:0]  win_frames,
  input  logic [THR_W-1:0]  dep_thresh,
  input  logic [IDLE_W-1:0] idle_limit,
  output logic              disqualify
);

  logic [WIN_W-1:0]  win_cnt, win_cnt_d;
  logic [THR_W-1:0]  dep_cnt, dep_cnt_d, cnt_inc;
  logic              dep_dq, dep_dq_d;
  logic [IDLE_W-1:0] idle_cnt, idle_cnt_d;
  logic              close, over, idle_hit, dq_d;

  always_comb begin
    close   = ({1'b0, win_cnt} + 1'b1) >= {1'b0, win_frames};
    cnt_inc = (dep_pulse && dep_cnt != '1) ? dep_cnt + 1'b1 : dep_cnt;
    over    = cnt_inc > dep_thresh;

    win_cnt_d = win_cnt;
    if (frame_tick) win_cnt_d = close ? '0 : win_cnt + 1'b1;

    if (frame_tick && close) begin
      dep_cnt_d = '0;
      dep_dq_d  = over;
    end else begin
      dep_cnt_d = cnt_inc;
      dep_dq_d  = dep_dq | over;
    end

    if (activity)
      idle_cnt_d = '0;
    else if (idle_cnt >= idle_limit)
      idle_cnt_d = idle_cnt;
    else
      idle_cnt_d = idle_cnt + 1'b1;
    idle_hit = idle_cnt_d >= idle_limit;

    dq_d = dep_dq_d | idle_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt    <= '0;
      dep_cnt    <= '0;
      dep_dq     <= 1'b0;
      idle_cnt   <= '0;
      disqualify <= 1'b0;
    end else begin
      win_cnt    <= win_cnt_d;
      dep_cnt    <= dep_cnt_d;
      dep_dq     <= dep_dq_d;
      idle_cnt   <= idle_cnt_d;
      disqualify <= dq_d;
    end
  end

endmodule

// File: rtl/ami_cc_decoder.sv
module ami_cc_decoder
  import ami_cc_pkg::*;
#(
  parameter int FRAME_MARKS = 8,
  parameter int ACQ_VIOL    = 2,
  parameter int LOSS_ERR    = 3,
  parameter int WIN_W       = 8,
  parameter int THR_W       = 8,
  parameter int IDLE_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rail_p,
  input  logic              rail_n,
  input  logic [WIN_W-1:0]  win_frames,
  input  logic [THR_W-1:0]  dep_thresh,
  input  logic [IDLE_W-1:0] idle_limit,
  output logic              bit_en,
  output logic              frame_pulse,
  output logic              framed,
  output logic              disqualify
);

  logic [1:0] rst_sync;
  logic       rst_i;
  mark_t      mk;
  logic       dep_pulse, frame_tick;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  ami_mark_det u_det (
    .clk    (clk),
    .rst_n  (rst_i),
    .rail_p (rail_p),
    .rail_n (rail_n),
    .mk_q   (mk)
  );

  ami_framer #(
    .FRAME_MARKS (FRAME_MARKS),
    .ACQ_VIOL    (ACQ_VIOL),
    .LOSS_ERR    (LOSS_ERR)
  ) u_frm (
    .clk         (clk),
    .rst_n       (rst_i),
    .mk          (mk),
    .bit_en      (bit_en),
    .frame_pulse (frame_pulse),
    .framed      (framed),
    .dep_pulse   (dep_pulse),
    .frame_tick  (frame_tick)
  );

  ami_qual_mon #(
    .WIN_W  (WIN_W),
    .THR_W  (THR_W),
    .IDLE_W (IDLE_W)
  ) u_mon (
    .clk        (clk),
    .rst_n      (rst_i),
    .dep_pulse  (dep_pulse),
    .frame_tick (frame_tick),
    .activity   (mk.valid | mk.bad),
    .win_frames (win_frames),
    .dep_thresh (dep_thresh),
    .idle_limit (idle_limit),
    .disqualify (disqualify)
  );

endmodule

// File: rtl/ami_cc_decoder_chk.sv
module ami_cc_decoder_chk #(
  parameter int IDLE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rail_p,
  input logic              rail_n,
  input logic [IDLE_W-1:0] idle_limit,
  input logic              bit_en,
  input logic              frame_pulse,
  input logic              framed,
  input logic              disqualify
);

  logic              pp, pn, vr1, vr2, any_rise, ok_rise;
  logic [IDLE_W+1:0] quiet;

  assign any_rise = (rail_p & ~pp) | (rail_n & ~pn);
  assign ok_rise  = any_rise & ~(rail_p & rail_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pp    <= 1'b0;
      pn    <= 1'b0;
      vr1   <= 1'b0;
      vr2   <= 1'b0;
      quiet <= '0;
    end else begin
      pp  <= rail_p;
      pn  <= rail_n;
      vr1 <= ok_rise;
      vr2 <= vr1;
      if (any_rise)        quiet <= '0;
      else if (quiet != '1) quiet <= quiet + 1'b1;
    end
  end

  // R1
  bit_en_from_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |-> vr2);

  // R5
  pulse_on_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> (bit_en && framed));

  // R4
  acquire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(framed) |-> frame_pulse);

  // R8
  idle_dq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet > ({2'b00, idle_limit} + 6)) |-> disqualify);

endmodule

bind ami_cc_decoder ami_cc_decoder_chk #(.IDLE_W(IDLE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rail_p      (rail_p),
  .rail_n      (rail_n),
  .idle_limit  (idle_limit),
  .bit_en      (bit_en),
  .frame_pulse (frame_pulse),
  .framed      (framed),
  .disqualify  (disqualify)
);

// File: tb/ami_cc_decoder_test.sv
module ami_cc_decoder_test;

  logic        clk;
  logic        rst_n;
  logic        rail_p, rail_n;
  logic [7:0]  win_frames;
  logic [7:0]  dep_thresh;
  logic [15:0] idle_limit;
  logic        bit_en, frame_pulse, framed, disqualify;

  int checks, fails;
  logic bpol;
  logic last_be, last_be_nx, last_fp, last_fr, last_dq;

  ami_cc_decoder uut (
    .clk (clk), .rst_n (rst_n), .rail_p (rail_p), .rail_n (rail_n),
    .win_frames (win_frames), .dep_thresh (dep_thresh), .idle_limit (idle_limit),
    .bit_en (bit_en), .frame_pulse (frame_pulse), .framed (framed),
    .disqualify (disqualify)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] w, input logic [7:0] t, input logic [15:0] idl);
    @(negedge clk);
    rst_n = 1'b0; rail_p = 1'b0; rail_n = 1'b0;
    win_frames = w; dep_thresh = t; idle_limit = idl;
    bpol = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // drive one sample, capture outputs at their due cycles
  task automatic send_raw(input logic p, input logic n);
    rail_p = p; rail_n = n;
    @(negedge clk);
    rail_p = 1'b0; rail_n = 1'b0;
    @(negedge clk);
    last_be = bit_en; last_fp = frame_pulse; last_fr = framed;
    @(negedge clk);
    last_be_nx = bit_en; last_dq = disqualify;
    @(negedge clk);
  endtask

  task automatic send_alt();
    bpol = ~bpol;
    send_raw(bpol, ~bpol);
  endtask

  task automatic send_viol();
    send_raw(bpol, ~bpol);
  endtask

  task automatic acquire();
    send_alt();
    send_viol();
    for (int i = 0; i < 7; i++) send_alt();
    send_viol();
    chk(last_fr == 1'b0, "R4 not framed after one good violation", last_fr, 0);
    chk(last_fp == 1'b0, "R5 no pulse before framing", last_fp, 0);
    for (int i = 0; i < 7; i++) send_alt();
    send_viol();
    chk(last_fr == 1'b1, "R4 framed after second good violation", last_fr, 1);
    chk(last_fp == 1'b1, "R5 pulse on acquiring violation", last_fp, 1);
  endtask

  task automatic t_reset();
    do_reset(8'd255, 8'd10, 16'hFFFF);
    chk(bit_en == 1'b0, "R9 bit_en after reset", bit_en, 0);
    chk(frame_pulse == 1'b0, "R9 frame_pulse after reset", frame_pulse, 0);
    chk(framed == 1'b0, "R9 framed after reset", framed, 0);
    chk(disqualify == 1'b0, "R9 disqualify after reset", disqualify, 0);
  endtask

  task automatic t_marks();
    do_reset(8'd255, 8'd10, 16'hFFFF);
    send_raw(1'b1, 1'b0);
    chk(last_be == 1'b1, "R1 bit_en on positive mark", last_be, 1);
    chk(last_be_nx == 1'b0, "R1 bit_en lasts one cycle", last_be_nx, 0);
    send_raw(1'b0, 1'b1);
    chk(last_be == 1'b1, "R1 bit_en on negative mark", last_be, 1);
  endtask

  task automatic t_both();
    do_reset(8'd255, 8'd0, 16'hFFFF);
    send_raw(1'b1, 1'b1);
    chk(last_be == 1'b0, "R2 no bit_en on both rails", last_be, 0);
    chk(last_dq == 1'b1, "R2 both rails is a departure", last_dq, 1);
  endtask

  task automatic t_acq();
    do_reset(8'd255, 8'd0, 16'hFFFF);
    acquire();
    for (int i = 0; i < 7; i++) begin
      send_alt();
      chk(last_fp == 1'b0, "R5 no pulse on ordinary mark", last_fp, 0);
    end
    send_viol();
    chk(last_fp == 1'b1, "R5 pulse on next boundary", last_fp, 1);
    chk(last_dq == 1'b0, "R7 clean pattern qualifies", last_dq, 0);
  endtask

  task automatic t_loss();
    do_reset(8'd255, 8'd2, 16'hFFFF);
    acquire();
    for (int i = 0; i < 16; i++) send_alt();
    chk(last_fr == 1'b1, "R6 framed after two missing violations", last_fr, 1);
    chk(last_dq == 1'b0, "R7 two departures within threshold", last_dq, 0);
    for (int i = 0; i < 8; i++) send_alt();
    chk(last_fr == 1'b0, "R6 framing lost after three errors", last_fr, 0);
    chk(last_dq == 1'b1, "R3 missing violations count over threshold", last_dq, 1);
  endtask

  task automatic t_early();
    do_reset(8'd255, 8'd0, 16'hFFFF);
    acquire();
    for (int i = 0; i < 4; i++) send_alt();
    send_viol();
    chk(last_dq == 1'b1, "R3 early violation is a departure", last_dq, 1);
    chk(last_fr == 1'b1, "R6 one error keeps framing", last_fr, 1);
    chk(last_fp == 1'b1, "R5 pulse on violation while framed", last_fp, 1);
    for (int i = 0; i < 7; i++) send_alt();
    send_viol();
    chk(last_fr == 1'b1, "R6 good violation keeps framing", last_fr, 1);
  endtask

  task automatic t_window();
    do_reset(8'd2, 8'd2, 16'hFFFF);
    send_raw(1'b1, 1'b1);
    send_raw(1'b1, 1'b1);
    chk(last_dq == 1'b0, "R7 count at threshold qualifies", last_dq, 0);
    send_raw(1'b1, 1'b1);
    chk(last_dq == 1'b1, "R7 count above threshold disqualifies", last_dq, 1);
    for (int i = 0; i < 16; i++) send_alt();
    chk(last_dq == 1'b1, "R7 held through close of bad window", last_dq, 1);
    for (int i = 0; i < 16; i++) send_alt();
    chk(last_dq == 1'b0, "R7 cleared after clean window", last_dq, 0);
  endtask

  task automatic t_idle();
    do_reset(8'd255, 8'd10, 16'd20);
    repeat (6) @(negedge clk);
    chk(disqualify == 1'b0, "R8 before idle limit", disqualify, 0);
    repeat (20) @(negedge clk);
    chk(disqualify == 1'b1, "R8 after idle limit", disqualify, 1);
    send_raw(1'b1, 1'b0);
    chk(last_dq == 1'b0, "R8 cleared by mark", last_dq, 0);
    repeat (30) @(negedge clk);
    chk(disqualify == 1'b1, "R8 silent again", disqualify, 1);
  endtask

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; rail_p = 1'b0; rail_n = 1'b0;
    win_frames = 8'd255; dep_thresh = 8'd10; idle_limit = 16'hFFFF;
    bpol = 1'b0;
    t_reset();
    t_marks();
    t_both();
    t_acq();
    t_loss();
    t_early();
    t_window();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule